// File: doc/BRIEF.md
# Muxed-D Scan Chain Core with Test-Mode Repairs

This block is a small sequential core whose state flops are built as multiplexed-D scan cells and stitched into one serial chain. A scan-enable input steers every cell between its functional next-state value and the output of its upstream neighbour. A test-mode input and the scan-enable input together select one of three operating types: normal, shift and capture.

The core also carries the standard repairs that keep a design testable through scan. The functional clock enable is overridden during test, so the cells always advance. An internally derived asynchronous clear is blocked for the whole test operation. Shared-bus driver enables are forced to a single safe driver during shift. The output buffer of a bidirectional pad is turned off during shift, so the tester owns the pin. In normal mode all of this forcing logic is transparent.

The chain length, the number of bus drivers, the driver kept on during shift and the clear polarity are parameters.

Top module: `scan_repair_core`

## Requirements
- R1: With tm_i=1 and se_i=1, every rising clock edge loads si_i into cell 0 and the value of cell i-1 into cell i; so_o always shows the last cell, so a bit reaches so_o after N_CELLS edges.
- R2: With tm_i=1 and se_i=0 (capture), one rising edge loads every cell with its functional next state: cell 0 takes q[N-1] ^ pi_i[0] ^ pad_in_i, and cell i>0 takes q[i-1] ^ pi_i[i].
- R3: With tm_i=0, se_i=0 and fn_ce_i=0, the cells hold their value across clock edges. When tm_i=1 or se_i=1, the cells update on every edge whatever fn_ce_i is.
- R4: While tm_i=0, clr_src_i=1 (default polarity) clears all cells at once without a clock edge. While tm_i=1, clr_src_i has no effect on the cells.
- R5: While se_i=1, bus_en_o equals one-hot bit FORCE_IDX (default bit 0, value 3'b001). While se_i=0, bus_en_o[k] is 1 exactly when q[1:0] equals k+1.
- R6: While se_i=1, pad_oe_o is 0. While se_i=0, pad_oe_o equals the last cell q[N-1]. pad_out_o always equals q[0].
- R7: In normal mode (tm_i=0, se_i=0, fn_ce_i=1), each edge loads the same next state as in R2, and po_o always equals q ^ pi_i, bit for bit.
- R8: At most one bit of bus_en_o is 1 at any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all cells sample on the rising edge |
| tm_i | input | 1 | Test mode: 1 during shift and capture |
| se_i | input | 1 | Scan enable: 1 selects the serial path |
| si_i | input | 1 | Serial scan data into cell 0 |
| pi_i | input | N_CELLS | Primary inputs to the next-state and output logic |
| pad_in_i | input | 1 | Receive side of the bidirectional pad |
| fn_ce_i | input | 1 | Functional clock enable for the cells |
| clr_src_i | input | 1 | Asynchronous clear source, active high by default |
| so_o | output | 1 | Serial scan data out of the last cell |
| po_o | output | N_CELLS | Primary outputs, q ^ pi_i |
| bus_en_o | output | N_DRV | Tri-state driver enables of the shared bus |
| pad_oe_o | output | 1 | Output enable of the bidirectional pad buffer |
| pad_out_o | output | 1 | Transmit value of the bidirectional pad |

## Verification
Cell contents change on a rising edge and are read 2 ns after that edge through po_o (with pi_i at zero) and so_o. The scenario tasks therefore update the expected state once per edge and compare only after that edge settles. The bus enables, the pad enable and po_o are combinational, so they are checked in the same cycle that their inputs change. The asynchronous clear and its blocking are checked between edges, a few nanoseconds after clr_src_i moves, so that no clock edge can hide or cause the effect.

// File: rtl/scanfix_pkg.sv
package scanfix_pkg;

   // operating type, encoded as {tm, se}
   typedef enum logic [1:0] {
      OP_NORMAL  = 2'b00,
      OP_STRAY   = 2'b01,
      OP_CAPTURE = 2'b10,
      OP_SHIFT   = 2'b11
   } op_e;

   function automatic op_e decode_op(input logic tm, input logic se);
      return op_e'({tm, se});
   endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
   input  logic clk,
   input  logic clr,
   input  logic en,
   input  logic se,
   input  logic si,
   input  logic di,
   output logic q
);

   always_ff @(posedge clk or posedge clr) begin
      if (clr)
         q <= 1'b0;
      else if (en)
         q <= se ? si : di;
   end

   // R1: serial path taken when scan enable is high
   p_cell_shift_r1: assert property (@(posedge clk) disable iff (clr)
      (en && se) |=> (q == $past(si)));

   // R3: a disabled cell keeps its value
   p_cell_hold_r3: assert property (@(posedge clk) disable iff (clr)
      !en |=> (q == $past(q)));

endmodule

// File: rtl/test_ctrl.sv
module test_ctrl
   import scanfix_pkg::*;
#(
   parameter bit CLR_ACT_HIGH = 1'b1
) (
   input  logic tm,
   input  logic se,
   input  logic fn_ce,
   input  logic clr_src,
   output logic cell_en,
   output logic clr_eff
);

   logic clr_req;
   op_e  op;

   generate
      if (CLR_ACT_HIGH) begin : g_clr_high
         assign clr_req = clr_src;
      end else begin : g_clr_low
         assign clr_req = ~clr_src;
      end
   endgenerate

   assign op = decode_op(tm, se);

   // clock-enable override: any test activity forces the cells to advance
   always_comb begin
      case (op)
         OP_NORMAL: cell_en = fn_ce;
         default:   cell_en = 1'b1;
      endcase
   end

   // internal clear is blocked for the whole test operation
   assign clr_eff = clr_req & ~tm;

endmodule

// File: rtl/bus_guard.sv
module bus_guard #(
   parameter int N_DRV     = 3,
   parameter int SEL_W     = 2,
   parameter int FORCE_IDX = 0
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             se,
   input  logic [SEL_W-1:0] sel,
   input  logic             oe_fn,
   output logic [N_DRV-1:0] bus_en,
   output logic             pad_oe
);

   localparam logic [N_DRV-1:0] SAFE_EN = N_DRV'(1) << FORCE_IDX;

   generate
      for (genvar k = 0; k < N_DRV; k++) begin : g_drv
         localparam logic [SEL_W-1:0] CODE = SEL_W'(k + 1);
         localparam bit               SAFE = (k == FORCE_IDX);
         assign bus_en[k] = se ? SAFE : (sel == CODE);
      end
   endgenerate

   // bidirectional pad: tester owns the pin during shift
   assign pad_oe = oe_fn & ~se;

   // R8: never two drivers on the bus
   p_one_drv_r8: assert property (@(posedge clk) disable iff (clr)
      $onehot0(bus_en));

   // R5: the safe driver alone during shift
   p_shift_drv_r5: assert property (@(posedge clk) disable iff (clr)
      se |-> (bus_en == SAFE_EN));

   // R6: pad buffer off during shift
   p_pad_off_r6: assert property (@(posedge clk) disable iff (clr)
      se |-> !pad_oe);

endmodule

// File: rtl/scan_repair_core.sv
module scan_repair_core #(
   parameter int N_CELLS      = 3,
   parameter int N_DRV        = 3,
   parameter int FORCE_IDX    = 0,
   parameter bit CLR_ACT_HIGH = 1'b1
) (
   input  logic               clk_i,
   input  logic               tm_i,
   input  logic               se_i,
   input  logic               si_i,
   input  logic [N_CELLS-1:0] pi_i,
   input  logic               pad_in_i,
   input  logic               fn_ce_i,
   input  logic               clr_src_i,
   output logic               so_o,
   output logic [N_CELLS-1:0] po_o,
   output logic [N_DRV-1:0]   bus_en_o,
   output logic               pad_oe_o,
   output logic               pad_out_o
);

   localparam int SEL_W = $clog2(N_DRV + 1);

   generate
      if (N_CELLS < 2) begin : g_bad_cells
         $error("scan_repair_core: N_CELLS must be at least 2");
      end
      if (N_DRV < 1) begin : g_bad_drv
         $error("scan_repair_core: N_DRV must be at least 1");
      end
      if (N_CELLS < SEL_W) begin : g_bad_sel
         $error("scan_repair_core: N_CELLS too small for the bus select");
      end
      if (FORCE_IDX < 0 || FORCE_IDX >= N_DRV) begin : g_bad_force
         $error("scan_repair_core: FORCE_IDX out of range");
      end
   endgenerate

   logic               cell_en;
   logic               clr_eff;
   logic [N_CELLS-1:0] q;
   logic [N_CELLS-1:0] di_vec;
   logic [N_CELLS-1:0] si_vec;

   test_ctrl #(
      .CLR_ACT_HIGH (CLR_ACT_HIGH)
   ) u_ctrl (
      .tm      (tm_i),
      .se      (se_i),
      .fn_ce   (fn_ce_i),
      .clr_src (clr_src_i),
      .cell_en (cell_en),
      .clr_eff (clr_eff)
   );

   // combinational next-state logic and chain stitching
   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         if (i == 0) begin : g_head
            assign di_vec[i] = q[N_CELLS-1] ^ pi_i[i] ^ pad_in_i;
            assign si_vec[i] = si_i;
         end else begin : g_body
            assign di_vec[i] = q[i-1] ^ pi_i[i];
            assign si_vec[i] = q[i-1];
         end

         scan_cell u_cell (
            .clk (clk_i),
            .clr (clr_eff),
            .en  (cell_en),
            .se  (se_i),
            .si  (si_vec[i]),
            .di  (di_vec[i]),
            .q   (q[i])
         );
      end
   endgenerate

   bus_guard #(
      .N_DRV     (N_DRV),
      .SEL_W     (SEL_W),
      .FORCE_IDX (FORCE_IDX)
   ) u_bus (
      .clk    (clk_i),
      .clr    (clr_eff),
      .se     (se_i),
      .sel    (q[SEL_W-1:0]),
      .oe_fn  (q[N_CELLS-1]),
      .bus_en (bus_en_o),
      .pad_oe (pad_oe_o)
   );

   assign so_o      = q[N_CELLS-1];
   assign po_o      = q ^ pi_i;
   assign pad_out_o = q[0];

   // R1: the scan input arrives in cell 0 one edge later
   p_chain_head_r1: assert property (@(posedge clk_i) disable iff (clr_eff)
      (tm_i && se_i) |=> (q[0] == $past(si_i)));

   // R2: capture loads the functional response into all cells
   p_capture_r2: assert property (@(posedge clk_i) disable iff (clr_eff)
      (tm_i && !se_i) |=> (q == $past(di_vec)));

   // R3: functional enable low in normal mode holds state
   p_ce_hold_r3: assert property (@(posedge clk_i) disable iff (clr_eff)
      (!tm_i && !se_i && !fn_ce_i) |=> $stable(q));

   // R4: test mode never lets the internal clear through
   p_tm_blocks_clr_r4: assert property (@(posedge clk_i)
      tm_i |-> !clr_eff);

   // R7: normal mode with enable follows the next-state logic
   p_normal_r7: assert property (@(posedge clk_i) disable iff (clr_eff)
      (!tm_i && !se_i && fn_ce_i) |=> (q == $past(di_vec)));

endmodule

// File: tb/scan_repair_core_tb.sv
`timescale 1ns/1ps
module scan_repair_core_tb;

   localparam int N = 3;

   logic         clk = 1'b0;
   logic         tm = 1'b0;
   logic         se = 1'b0;
   logic         si = 1'b0;
   logic [N-1:0] pi = '0;
   logic         pad_in = 1'b0;
   logic         fn_ce = 1'b0;
   logic         clr_src = 1'b1;
   logic         so;
   logic [N-1:0] po;
   logic [2:0]   bus_en;
   logic         pad_oe;
   logic         pad_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [N-1:0] exp_q = '0;

   always #10 clk = ~clk;

   scan_repair_core u_dut (
      .clk_i     (clk),
      .tm_i      (tm),
      .se_i      (se),
      .si_i      (si),
      .pi_i      (pi),
      .pad_in_i  (pad_in),
      .fn_ce_i   (fn_ce),
      .clr_src_i (clr_src),
      .so_o      (so),
      .po_o      (po),
      .bus_en_o  (bus_en),
      .pad_oe_o  (pad_oe),
      .pad_out_o (pad_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // next state per R2/R7
   function automatic logic [N-1:0] nxt(input logic [N-1:0] s, input logic [N-1:0] p,
                                       input logic pd);
      logic [N-1:0] r;
      r[0] = s[N-1] ^ p[0] ^ pd;
      for (int i = 1; i < N; i++) r[i] = s[i-1] ^ p[i];
      return r;
   endfunction

   // bus enables per R5 with scan enable low
   function automatic logic [2:0] dec(input logic [N-1:0] s);
      logic [2:0] r;
      r = '0;
      for (int k = 0; k < 3; k++) r[k] = (s[1:0] == 2'(k + 1));
      return r;
   endfunction

   task automatic edge_wait();
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      tm = 0; se = 0; fn_ce = 0; pi = '0; pad_in = 0; clr_src = 1;
      repeat (2) edge_wait();
      exp_q = '0;
      chk("R4 reset clears cells", 32'(po), 32'(exp_q));
      chk("R5 bus idle after reset", 32'(bus_en), 32'h0);
      chk("R6 pad oe after reset", 32'(pad_oe), 32'h0);
      chk("R1 so after reset", 32'(so), 32'h0);
      clr_src = 0;
   endtask

   task automatic t_shift(input logic [2:0] bits);
      tm = 1; se = 1; fn_ce = 0; pi = '0;
      for (int b = 0; b < 3; b++) begin
         si = bits[b];
         edge_wait();
         exp_q = {exp_q[N-2:0], bits[b]};
         chk("R1 R3 shift state", 32'(po), 32'(exp_q));
         chk("R1 so tail", 32'(so), 32'(exp_q[N-1]));
         chk("R5 forced driver", 32'(bus_en), 32'h1);
         chk("R6 pad off in shift", 32'(pad_oe), 32'h0);
      end
   endtask

   task automatic t_capture(input logic [N-1:0] p, input logic pd);
      tm = 1; se = 0; fn_ce = 0; pi = p; pad_in = pd;
      edge_wait();
      exp_q = nxt(exp_q, p, pd);
      chk("R2 capture response", 32'(po), 32'(exp_q ^ p));
      pi = '0;
      #1;
      chk("R2 capture state", 32'(po), 32'(exp_q));
   endtask

   task automatic t_hold();
      tm = 0; se = 0; fn_ce = 0; pi = '0; pad_in = 1;
      repeat (3) edge_wait();
      chk("R3 hold in normal", 32'(po), 32'(exp_q));
      chk("R5 decode normal", 32'(bus_en), 32'(dec(exp_q)));
      chk("R6 pad oe follows last cell", 32'(pad_oe), 32'(exp_q[N-1]));
      chk("R6 pad out follows cell 0", 32'(pad_out), 32'(exp_q[0]));
   endtask

   task automatic t_normal();
      logic [N-1:0] pats [6] = '{3'b011, 3'b101, 3'b000, 3'b111, 3'b010, 3'b110};
      tm = 0; se = 0; fn_ce = 1;
      for (int j = 0; j < 6; j++) begin
         pi = pats[j];
         pad_in = j[0];
         edge_wait();
         exp_q = nxt(exp_q, pats[j], j[0]);
         chk("R7 normal po", 32'(po), 32'(exp_q ^ pats[j]));
         chk("R5 R8 bus decode", 32'(bus_en), 32'(dec(exp_q)));
         chk("R6 pad oe normal", 32'(pad_oe), 32'(exp_q[N-1]));
      end
      fn_ce = 0; pi = '0;
   endtask

   task automatic t_clr_block();
      t_shift(3'b111);
      tm = 1; se = 1; fn_ce = 0;
      clr_src = 1;
      #4;
      chk("R4 clear blocked in test", 32'(po), 32'(exp_q));
      clr_src = 0;
      edge_wait();
      se = 0; tm = 0;
      exp_q = {exp_q[N-2:0], si};
      #1;
      chk("R4 state before clear", 32'(po), 32'(exp_q));
      clr_src = 1;
      #3;
      exp_q = '0;
      chk("R4 clear without edge", 32'(po), 32'(exp_q));
      edge_wait();
      clr_src = 0;
   endtask

   initial begin
      #20000000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #5;
      t_reset();
      t_shift(3'b101);
      t_capture(3'b110, 1'b1);
      t_hold();
      t_normal();
      t_clr_block();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule